// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers 32 top-level interrupt sources and a second tier of 32 peripheral sources into one CPU interrupt line and a vector that names the source to service. Three top-level positions do not come from pins. Each carries the OR of one range of the second tier, after that tier's mask has been applied. Every source has a fixed type. A level source is pending while its input is high. An edge source is caught on a rising input and stays pending until software clears it.

Software programs the controller through a single-cycle write port with a 3-bit register select. The two mask registers are written whole. A soft-request register feeds the top level. The two edge-latch registers use write-to-clear: a 0 in the written word clears that edge latch, and a 1 leaves it alone. The vector points to the lowest-numbered pending top-level source. When that source is a group summary, the vector points instead to the lowest pending, unmasked second-tier source in that group.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, `cpu_irq_o` and `vec_valid_o` are low and `vec_o` is 0. Both masks, the top edge latches, the soft-request register and the second-tier status are all clear, so unmasking everything with no input asserted produces no request.
- R2: A top-level level source is pending while its input is high and its mask bit is 1. It stops being pending once the input falls.
- R3: Top-level sources 16–19, 22–24 and 28–31 are edge type. A rising input sets a latch, and the latch stays set after the input falls. A write with select 1 clears each latch whose bit in the data is 0 and leaves each latch whose bit is 1.
- R4: A source whose mask bit is 0 contributes nothing, at either tier. Setting the mask bit of a source that is already pending makes it visible. Top mask is select 0, second-tier mask is select 3.
- R5: Among pending top-level bits, the lowest-numbered one selects the vector.
- R6: Top bit 4 is the OR of masked pending second-tier sources 16–31. Top bit 5 is the OR of sources 8–15, and top bit 6 is the OR of sources 0–7. The top-level input pins at positions 4–6 are ignored.
- R7: When the winning top bit is a group summary, `vec_o` is 32 plus the lowest masked pending second-tier source inside that group. Otherwise `vec_o` is the top bit number, from 0 to 31.
- R8: Second-tier sources 16, 22 and 28 are edge type and latch a rising input. A write with select 4 clears each of these latches whose data bit is 0. Second-tier level sources ignore that write.
- R9: Each bit set in the soft-request register (select 2) makes the same top-level position pending, except positions 4–6, where soft bits are ignored.
- R10: With no masked pending top-level bit, the request is spurious: `cpu_irq_o` = 0, `vec_valid_o` = 0 and `vec_o` = 0. Otherwise `cpu_irq_o` = `vec_valid_o` = 1.
- R11: A write with select 5, 6 or 7 changes no state.
- R12: An input change sampled at one rising clock edge, or a write applied at that edge, shows on the outputs after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| top_src_i | input | 32 | Raw top-level source inputs (positions 4–6 unused) |
| sub_src_i | input | 32 | Raw second-tier source inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select: 0 top mask, 1 top latch clear, 2 soft request, 3 second-tier mask, 4 second-tier latch clear |
| wr_data_i | input | 32 | Write data |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |
| vec_valid_o | output | 1 | Vector is meaningful |
| vec_o | output | 6 | Selected source: 0–31 top level, 32–63 second tier |

## Verification
The hardest situation to reach is one where a second-tier edge source stays latched after its input has gone back low, while pending sources in other groups compete with it. In that situation the vector must follow the winning summary bit and not the lowest second-tier index overall. The stimulus gets there by pulsing a second-tier edge input for a single cycle, then raising level sources in lower- and higher-priority groups, and then issuing clearing writes whose data keeps some bits at 1. Each state is checked at the ports as the resulting vector.

// File: rtl/irq_cascade_pkg.sv
// Shared definitions for the cascaded interrupt controller.
// Assumes 3-bit register selects; any unlisted select value is a no-op.
package irq_cascade_pkg;

    typedef enum logic [2:0] {
        WSEL_TOP_MASK = 3'd0,
        WSEL_TOP_ACK  = 3'd1,
        WSEL_SOFT     = 3'd2,
        WSEL_SUB_MASK = 3'd3,
        WSEL_SUB_ACK  = 3'd4
    } wsel_e;

    // Contiguous bit span [lo..hi] as a 64-bit mask (caller truncates).
    function automatic logic [63:0] span_mask(int lo, int hi);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_prio_enc.sv
// Lowest-index-wins priority encoder.
// Assumes W is at least 2; idx is 0 when no request is present.
module irq_prio_enc #(
    parameter int W     = 32,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_src_stage.sv
// Per-source capture stage for one tier of the controller.
// Level sources register the raw input every cycle. Edge sources set
// on a rising input and clear only when a clearing write has a 0 in
// their bit; a rise in the same cycle as a clear keeps the bit set.
// Assumes raw inputs are already synchronous to clk.
module irq_src_stage #(
    parameter int           W         = 32,
    parameter logic [W-1:0] EDGE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic         ack_we,
    input  logic [W-1:0] ack_data,
    output logic [W-1:0] stat
);

    logic [W-1:0] prev_q;

    // Remember last raw sample for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= raw;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            logic keep;
            assign keep = ack_we ? ack_data[i] : 1'b1;
            // Edge latch: set on rise, clear on acknowledge with 0.
            always_ff @(posedge clk) begin
                if (!rst_n) stat[i] <= 1'b0;
                else        stat[i] <= (stat[i] & keep) | (raw[i] & ~prev_q[i]);
            end
        end else begin : g_level
            // Level capture: follow the input, writes ignored.
            always_ff @(posedge clk) begin
                if (!rst_n) stat[i] <= 1'b0;
                else        stat[i] <= raw[i];
            end
        end
    end

endmodule

// File: rtl/irq_group_sum.sv
// Second-tier group summariser.
// For each group it gives the OR of the masked pending bits in the
// group's range and the lowest pending index inside that range.
// Assumes ranges are given as packed 8-bit lo/hi fields, one per group.
module irq_group_sum #(
    parameter int                  NSRC   = 32,
    parameter int                  NGRP   = 3,
    parameter logic [NGRP*8-1:0]   GRP_LO = {8'd0, 8'd8, 8'd16},
    parameter logic [NGRP*8-1:0]   GRP_HI = {8'd7, 8'd15, 8'd31},
    localparam int                 IDX_W  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]       pend,
    output logic [NGRP-1:0]       sum,
    output logic [NGRP*IDX_W-1:0] grp_idx
);
    import irq_cascade_pkg::*;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = int'(GRP_LO[g*8 +: 8]);
        localparam int HI = int'(GRP_HI[g*8 +: 8]);
        localparam logic [63:0] SPAN64 = span_mask(LO, HI);
        localparam logic [NSRC-1:0] SPAN = SPAN64[NSRC-1:0];

        logic [NSRC-1:0] in_grp;
        assign in_grp = pend & SPAN;

        irq_prio_enc #(.W(NSRC)) u_enc (
            .req (in_grp),
            .any (sum[g]),
            .idx (grp_idx[g*IDX_W +: IDX_W])
        );
    end

endmodule

// File: rtl/irq_cascade_ctrl.sv
// Cascaded two-level interrupt controller, top level.
// Combines registered top-level sources, soft requests and second-tier
// group summaries; masks them; encodes the lowest pending source into a
// registered vector and CPU request. Summary positions of the top tier
// take no pin or soft input. Assumes all inputs are synchronous to clk.
module irq_cascade_ctrl #(
    parameter int                 NSRC     = 32,
    parameter logic [NSRC-1:0]    TOP_EDGE = 32'hF1CF_0000,
    parameter logic [NSRC-1:0]    SUB_EDGE = 32'h1041_0000,
    parameter int                 NGRP     = 3,
    parameter logic [NGRP*8-1:0]  GRP_POS  = {8'd6, 8'd5, 8'd4},
    parameter logic [NGRP*8-1:0]  GRP_LO   = {8'd0, 8'd8, 8'd16},
    parameter logic [NGRP*8-1:0]  GRP_HI   = {8'd7, 8'd15, 8'd31},
    localparam int                IDX_W    = $clog2(NSRC),
    localparam int                VEC_W    = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  top_src_i,
    input  logic [NSRC-1:0]  sub_src_i,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_sel_i,
    input  logic [NSRC-1:0]  wr_data_i,
    output logic             cpu_irq_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o
);
    import irq_cascade_pkg::*;

    logic [NSRC-1:0]       top_mask_q;
    logic [NSRC-1:0]       sub_mask_q;
    logic [NSRC-1:0]       soft_q;
    logic [NSRC-1:0]       sum_map;
    logic [NSRC-1:0]       sum_bits;
    logic [NSRC-1:0]       top_hold;
    logic [NSRC-1:0]       sub_stat;
    logic [NSRC-1:0]       sub_pend;
    logic [NSRC-1:0]       top_eff;
    logic [NGRP-1:0]       grp_sum;
    logic [NGRP*IDX_W-1:0] grp_idx;
    logic                  top_any;
    logic [IDX_W-1:0]      top_idx;
    logic [VEC_W-1:0]      vec_nxt;
    logic                  top_ack_we;
    logic                  sub_ack_we;

    assign top_ack_we = wr_en_i && (wr_sel_i == WSEL_TOP_ACK);
    assign sub_ack_we = wr_en_i && (wr_sel_i == WSEL_SUB_ACK);

    // Mask and soft-request registers, written whole by select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_mask_q <= '0;
            sub_mask_q <= '0;
            soft_q     <= '0;
        end else if (wr_en_i) begin
            if (wr_sel_i == WSEL_TOP_MASK) top_mask_q <= wr_data_i;
            if (wr_sel_i == WSEL_SUB_MASK) sub_mask_q <= wr_data_i;
            if (wr_sel_i == WSEL_SOFT)     soft_q     <= wr_data_i;
        end
    end

    // Position map of group summaries inside the top tier.
    always_comb begin
        sum_map = '0;
        for (int g = 0; g < NGRP; g++) sum_map[int'(GRP_POS[g*8 +: 8])] = 1'b1;
    end

    irq_src_stage #(.W(NSRC), .EDGE_MASK(SUB_EDGE & ~sum_map_c(GRP_POS) & SUB_EDGE)) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (sub_src_i),
        .ack_we   (sub_ack_we),
        .ack_data (wr_data_i),
        .stat     (sub_stat)
    );

    irq_src_stage #(.W(NSRC), .EDGE_MASK(TOP_EDGE & ~sum_map_c(GRP_POS))) u_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (top_src_i & ~sum_map),
        .ack_we   (top_ack_we),
        .ack_data (wr_data_i),
        .stat     (top_hold)
    );

    assign sub_pend = sub_stat & sub_mask_q;

    irq_group_sum #(
        .NSRC   (NSRC),
        .NGRP   (NGRP),
        .GRP_LO (GRP_LO),
        .GRP_HI (GRP_HI)
    ) u_grp (
        .pend    (sub_pend),
        .sum     (grp_sum),
        .grp_idx (grp_idx)
    );

    // Place each group summary on its top-tier position.
    always_comb begin
        sum_bits = '0;
        for (int g = 0; g < NGRP; g++) sum_bits[int'(GRP_POS[g*8 +: 8])] = grp_sum[g];
    end

    assign top_eff = (((top_hold | soft_q) & ~sum_map) | sum_bits) & top_mask_q;

    irq_prio_enc #(.W(NSRC)) u_top_enc (
        .req (top_eff),
        .any (top_any),
        .idx (top_idx)
    );

    // Vector select: descend into the group when a summary wins.
    always_comb begin
        vec_nxt = {1'b0, top_idx};
        for (int g = 0; g < NGRP; g++) begin
            if (top_idx == IDX_W'(GRP_POS[g*8 +: 8]))
                vec_nxt = VEC_W'(NSRC) + VEC_W'(grp_idx[g*IDX_W +: IDX_W]);
        end
        if (!top_any) vec_nxt = '0;
    end

    // Output register stage for request and vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_irq_o   <= 1'b0;
            vec_valid_o <= 1'b0;
            vec_o       <= '0;
        end else begin
            cpu_irq_o   <= |top_eff;
            vec_valid_o <= top_any;
            vec_o       <= vec_nxt;
        end
    end

    // Constant-time summary map used for parameter derivation.
    function automatic logic [NSRC-1:0] sum_map_c(logic [NGRP*8-1:0] pos);
        logic [NSRC-1:0] m;
        m = '0;
        for (int g = 0; g < NGRP; g++) m[int'(pos[g*8 +: 8])] = 1'b1;
        return m;
    endfunction

endmodule

// File: rtl/irq_cascade_chk.sv
// Property checker for the cascaded interrupt controller, bound to the top.
// Assumes the default select encoding from the shared package.
module irq_cascade_chk #(
    parameter int              NSRC     = 32,
    parameter logic [NSRC-1:0] TOP_EDGE = 32'hF1CF_0000,
    parameter logic [NSRC-1:0] SUB_EDGE = 32'h1041_0000,
    localparam int             IDX_W    = $clog2(NSRC),
    localparam int             VEC_W    = IDX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic [2:0]       wr_sel_i,
    input logic             vec_valid_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [NSRC-1:0]  top_mask_q,
    input logic [NSRC-1:0]  sub_mask_q,
    input logic [NSRC-1:0]  top_hold,
    input logic [NSRC-1:0]  sub_stat
);
    import irq_cascade_pkg::*;

    logic [NSRC-1:0] top_mask_d;
    logic [NSRC-1:0] sub_mask_d;

    // Mask values one cycle back, aligned with the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_mask_d <= '0;
            sub_mask_d <= '0;
        end else begin
            top_mask_d <= top_mask_q;
            sub_mask_d <= sub_mask_q;
        end
    end

    AST_SPURIOUS_ZERO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid_o |-> (vec_o == '0)); // R10

    AST_TOP_VEC_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && !vec_o[IDX_W]) |-> top_mask_d[vec_o[IDX_W-1:0]]); // R4

    AST_SUB_VEC_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && vec_o[IDX_W]) |-> sub_mask_d[vec_o[IDX_W-1:0]]); // R4

    AST_TOP_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_sel_i == WSEL_TOP_ACK)
        |=> ((top_hold & TOP_EDGE & $past(top_hold & TOP_EDGE)) == $past(top_hold & TOP_EDGE))); // R3

    AST_SUB_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_sel_i == WSEL_SUB_ACK)
        |=> ((sub_stat & SUB_EDGE & $past(sub_stat & SUB_EDGE)) == $past(sub_stat & SUB_EDGE))); // R8

endmodule

bind irq_cascade_ctrl irq_cascade_chk #(
    .NSRC     (NSRC),
    .TOP_EDGE (TOP_EDGE),
    .SUB_EDGE (SUB_EDGE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o),
    .top_mask_q  (top_mask_q),
    .sub_mask_q  (sub_mask_q),
    .top_hold    (top_hold),
    .sub_stat    (sub_stat)
);

// File: tb/sim_irq_cascade_ctrl.sv
// Scoreboard bench: the driver queues expected outputs, the monitor compares.
module sim_irq_cascade_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] top_src = '0;
    logic [31:0] sub_src = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        cpu_irq;
    logic        vec_valid;
    logic [5:0]  vec;

    always #4 clk = ~clk;

    irq_cascade_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .top_src_i   (top_src),
        .sub_src_i   (sub_src),
        .wr_en_i     (wr_en),
        .wr_sel_i    (wr_sel),
        .wr_data_i   (wr_data),
        .cpu_irq_o   (cpu_irq),
        .vec_valid_o (vec_valid),
        .vec_o       (vec)
    );

    typedef struct {
        string req;
        bit    valid;
        int    vnum;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    task automatic expect_out(string req, bit v, int vn);
        exp_t e;
        e.req = req;
        e.valid = v;
        e.vnum = v ? vn : 0;
        expq.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] s, logic [31:0] d);
        wr_en = 1'b1;
        wr_sel = s;
        wr_data = d;
        step(1);
        wr_en = 1'b0;
        step(1);
    endtask

    // Monitor: compare queued expectations mid-cycle.
    always @(negedge clk) begin
        exp_t e;
        #2;
        while (expq.size() > 0) begin
            e = expq.pop_front();
            checks++;
            if (vec_valid !== e.valid || cpu_irq !== e.valid || int'(vec) !== e.vnum) begin
                fails++;
                $display("FAIL %s: actual valid=%0b irq=%0b vec=%0d expected valid=%0b irq=%0b vec=%0d",
                         e.req, vec_valid, cpu_irq, vec, e.valid, e.valid, e.vnum);
            end
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        expect_out("R1", 0, 0);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        expect_out("R1", 0, 0);                 // nothing latched after reset

        // R12 latency and R2 level behaviour
        top_src[9] = 1'b1;
        step(1);
        expect_out("R12", 0, 0);
        step(1);
        expect_out("R2", 1, 9);
        top_src[2] = 1'b1; step(2);
        expect_out("R5", 1, 2);
        top_src[2] = 1'b0; step(2);
        expect_out("R5", 1, 9);
        top_src[9] = 1'b0; step(2);
        expect_out("R2", 0, 0);

        // R4 masking at the top
        wr(3'd0, ~(32'h1 << 12));
        top_src[12] = 1'b1; step(2);
        expect_out("R4", 0, 0);
        wr(3'd0, 32'hFFFF_FFFF);
        expect_out("R4", 1, 12);
        top_src[12] = 1'b0; step(2);

        // R3 top edge latch
        top_src[17] = 1'b1; step(1);
        top_src[17] = 1'b0; step(1);
        expect_out("R3", 1, 17);
        step(2);
        expect_out("R3", 1, 17);
        wr(3'd1, 32'hFFFF_FFFF);
        expect_out("R3", 1, 17);
        wr(3'd1, ~(32'h1 << 17));
        expect_out("R3", 0, 0);

        // R6 raw pins at summary positions ignored
        top_src[5] = 1'b1; step(2);
        expect_out("R6", 0, 0);
        top_src[5] = 1'b0;

        // R6/R7 group summaries and descent
        sub_src[9] = 1'b1; step(2);
        expect_out("R7", 1, 41);
        sub_src[3] = 1'b1; step(2);
        expect_out("R7", 1, 41);                // bit 5 beats bit 6
        sub_src[20] = 1'b1; step(2);
        expect_out("R6", 1, 52);                // bit 4 wins, group 16-31
        top_src[2] = 1'b1; step(2);
        expect_out("R5", 1, 2);
        top_src[2] = 1'b0; step(2);
        wr(3'd3, ~(32'h1 << 20));
        expect_out("R4", 1, 41);
        wr(3'd3, 32'hFFFF_FFFF);
        sub_src = '0; step(2);
        expect_out("R6", 0, 0);

        // R8 second-tier edge latch and level immunity
        sub_src[22] = 1'b1; step(1);
        sub_src[22] = 1'b0; step(1);
        expect_out("R8", 1, 54);
        wr(3'd4, 32'hFFFF_FFFF);
        expect_out("R8", 1, 54);
        wr(3'd4, ~(32'h1 << 22));
        expect_out("R8", 0, 0);
        sub_src[9] = 1'b1; step(2);
        wr(3'd4, 32'h0);
        expect_out("R8", 1, 41);
        sub_src[9] = 1'b0; step(2);

        // R9 soft requests
        wr(3'd2, 32'h1 << 29);
        expect_out("R9", 1, 29);
        wr(3'd2, 32'h1 << 5);
        expect_out("R9", 0, 0);
        wr(3'd2, 32'h0);

        // R11 unused selects
        wr(3'd5, 32'h0);
        wr(3'd7, 32'h0);
        top_src[9] = 1'b1; step(2);
        expect_out("R11", 1, 9);
        top_src[9] = 1'b0; step(2);

        // R1 reset clears soft request and masks
        wr(3'd2, 32'h1 << 30);
        expect_out("R9", 1, 30);
        rst_n = 1'b0; step(2);
        rst_n = 1'b1; step(1);
        expect_out("R1", 0, 0);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        expect_out("R1", 0, 0);

        step(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule